// File: doc/BRIEF.md
# Clock Configuration Write Lock

This block is the register bank that sits in front of a clock generation unit. It stores four clock-control registers and gates software writes to them, so that a runaway program cannot stop the main oscillator, switch the CPU clock away from it, or reprogram the PLL. It does not generate any clock. Its outputs are the stored fields, which the clock unit consumes.

Protection has two levels. A key register holds an enable bit. Only while that bit is 1 does a write to the guard register take effect. The guard register holds a one-way lock bit. Software sets the key bit, sets the lock, then clears the key bit. Once the lock is set, a chosen subset of clock fields and the whole PLL register ignore writes until the next system reset. All other bits stay writable.

A low-power wait request is granted only while the bank is unlocked. A request that arrives while locked is refused, and a one-cycle violation pulse is raised.

Top module: `clk_cfg_lock`

## Requirements
- R1: After reset, the registers read as follows: CTL0 (address 0) = 0x48, CTL1 (address 1) = 0x20, CTL2 (address 2) = 0x00, PLL (address 3) = 0x12, GUARD (address 4) = 0x00, KEY (address 5) = 0x00. lock_o and wait_violation are 0.
- R2: KEY bit 0 is the key enable, and it is freely writable. A write to GUARD while KEY bit 0 is 0 is ignored.
- R3: A write of 1 to GUARD bit 0 sets the lock. This takes effect only when three conditions hold: KEY bit 0 is 1, CTL0 bit 5 (main-clock stop) is 0, and CTL0 bit 7 (CPU source select) is 0. The lock appears on lock_o and on GUARD bit 0 from the next cycle.
- R4: An attempt to set the lock is ignored while CTL0 bit 5 is 1 or CTL0 bit 7 is 1.
- R5: Once set, the lock cannot be cleared by any write, even with the key enabled. Only reset clears it.
- R6: While locked, these bits keep their values on a write: CTL0 bits 2, 5 and 7, CTL1 bits 1:0, and CTL2 bit 0.
- R7: While locked, every bit of the PLL register keeps its value on a write.
- R8: While locked, all the other bits of CTL0, CTL1 and CTL2 take written data in the next cycle.
- R9: wait_grant equals wait_req while unlocked, and is 0 while locked.
- R10: A wait_req seen at a clock edge while locked gives wait_violation = 1 for exactly the following cycle.
- R11: Addresses 6 and 7 read as 0, and writes to them change no register. Unused bits of KEY and GUARD read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| lock_o | output | 1 | Lock state |
| wait_req | input | 1 | Low-power wait request |
| wait_grant | output | 1 | Wait request honoured |
| wait_violation | output | 1 | One-cycle pulse: wait requested while locked |
| ctl0_o | output | 8 | CTL0 contents to the clock unit |
| ctl1_o | output | 8 | CTL1 contents to the clock unit |
| ctl2_o | output | 8 | CTL2 contents to the clock unit |
| pll_o | output | 8 | PLL register contents to the clock unit |

## Verification
The assertions assume the following about the inputs:
- One register access per cycle.
- wr_en, addr, wdata and wait_req are stable around the rising edge.
- The released reset is seen only after the two-stage synchroniser has settled.

The stimulus meets these assumptions as follows:
- It drives every input one time unit after the falling edge.
- It holds the bus idle for several cycles after each reset release.
- It never issues a write and a read of different registers in the same cycle.

// File: rtl/ccwl_pkg.sv
package ccwl_pkg;
  localparam int DW     = 8;
  localparam int AW     = 3;
  localparam int NCFG   = 4;

  localparam logic [AW-1:0] ADDR_GUARD = 3'd4;
  localparam logic [AW-1:0] ADDR_KEY   = 3'd5;

  localparam int STOP_BIT = 5;
  localparam int SEL_BIT  = 7;
  localparam int LOCK_BIT = 0;
  localparam int KEY_BIT  = 0;

  // index 0..3 = CTL0, CTL1, CTL2, PLL
  localparam logic [NCFG-1:0][DW-1:0] CFG_LOCK_MASK = {8'hFF, 8'h01, 8'h03, 8'hA4};
  localparam logic [NCFG-1:0][DW-1:0] CFG_RST_VAL   = {8'h12, 8'h00, 8'h20, 8'h48};
endpackage

// File: rtl/ccwl_rst_sync.sv
module ccwl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/ccwl_cfg_reg.sv
module ccwl_cfg_reg #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    RST_VAL   = '0,
  parameter logic [W-1:0]    LOCK_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         lock,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic [W-1:0] hold_mask;
  logic         q_en;

  always_comb begin
    hold_mask = lock ? LOCK_MASK : '0;
    q_en      = we;
    q_d       = (q_r & hold_mask) | (wd & ~hold_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= RST_VAL;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;

  // R6 / R7: guarded bits are frozen while the lock is held
  p_masked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ((q_r & LOCK_MASK) == ($past(q_r) & LOCK_MASK)));

  // R8: free bits follow a write
  p_free_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q_r & ~LOCK_MASK) == ($past(wd) & ~LOCK_MASK)));
endmodule

// File: rtl/ccwl_lock_ctrl.sv
module ccwl_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic key_we,
  input  logic key_wd,
  input  logic guard_we,
  input  logic lock_wd,
  input  logic clk_ok,
  output logic key_o,
  output logic lock_o
);
  logic key_q, key_d, key_en;
  logic lock_q, lock_d, lock_en;

  always_comb begin
    key_en  = key_we;
    key_d   = key_wd;
    lock_en = guard_we && key_q && lock_wd && clk_ok && !lock_q;
    lock_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= 1'b0;
    else if (key_en) key_q <= key_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end

  assign key_o  = key_q;
  assign lock_o = lock_q;

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  p_key_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(key_q && guard_we));

  p_clock_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(clk_ok));
endmodule

// File: rtl/ccwl_wait_gate.sv
module ccwl_wait_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic lock,
  output logic grant,
  output logic viol
);
  logic viol_q, viol_d;

  always_comb viol_d = wait_req && lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign grant = wait_req && !lock;
  assign viol  = viol_q;

  p_viol_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> $past(wait_req) && $past(lock));

  p_viol_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && lock) |=> viol_q);

  p_no_grant_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock) && lock |-> !grant);
endmodule

// File: rtl/clk_cfg_lock.sv
module clk_cfg_lock
  import ccwl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          lock_o,
  input  logic          wait_req,
  output logic          wait_grant,
  output logic          wait_violation,
  output logic [DW-1:0] ctl0_o,
  output logic [DW-1:0] ctl1_o,
  output logic [DW-1:0] ctl2_o,
  output logic [DW-1:0] pll_o
);
  logic          rst_int_n;
  logic [DW-1:0] cfg_q [NCFG];
  logic          key_q;
  logic          lock_q;
  logic          clk_ok;
  logic          key_we, guard_we;

  ccwl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    ccwl_cfg_reg #(
      .W(DW), .RST_VAL(CFG_RST_VAL[i]), .LOCK_MASK(CFG_LOCK_MASK[i])
    ) u_reg (
      .clk(clk), .rst_n(rst_int_n),
      .we(wr_en && (addr == AW'(i))),
      .lock(lock_q), .wd(wdata), .q(cfg_q[i])
    );
  end

  always_comb begin
    key_we   = wr_en && (addr == ADDR_KEY);
    guard_we = wr_en && (addr == ADDR_GUARD);
    clk_ok   = !cfg_q[0][STOP_BIT] && !cfg_q[0][SEL_BIT];
  end

  ccwl_lock_ctrl u_lock (
    .clk(clk), .rst_n(rst_int_n),
    .key_we(key_we), .key_wd(wdata[KEY_BIT]),
    .guard_we(guard_we), .lock_wd(wdata[LOCK_BIT]),
    .clk_ok(clk_ok), .key_o(key_q), .lock_o(lock_q)
  );

  ccwl_wait_gate u_wait (
    .clk(clk), .rst_n(rst_int_n),
    .wait_req(wait_req), .lock(lock_q),
    .grant(wait_grant), .viol(wait_violation)
  );

  always_comb begin
    rdata = '0;
    if (addr < AW'(NCFG))        rdata = cfg_q[addr[1:0]];
    else if (addr == ADDR_GUARD) rdata[LOCK_BIT] = lock_q;
    else if (addr == ADDR_KEY)   rdata[KEY_BIT]  = key_q;
  end

  assign lock_o = lock_q;
  assign ctl0_o = cfg_q[0];
  assign ctl1_o = cfg_q[1];
  assign ctl2_o = cfg_q[2];
  assign pll_o  = cfg_q[3];

  // R7: PLL register never changes while locked
  p_pll_frozen_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    lock_q |=> $stable(pll_o));

  // R3: lock only rises on a guard write with bit set
  p_lock_by_write_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(lock_q) |-> $past(guard_we && wdata[LOCK_BIT]));

  // R11: a write to an unmapped address leaves the clock registers alone
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && addr > ADDR_KEY) |=> $stable(ctl0_o) && $stable(ctl1_o) && $stable(ctl2_o) && $stable(pll_o));
endmodule

// File: tb/sim_clk_cfg_lock.sv
module sim_clk_cfg_lock;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wait_req = 1'b0;
  logic [7:0] rdata, ctl0_o, ctl1_o, ctl2_o, pll_o;
  logic       lock_o, wait_grant, wait_violation;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string phase = "R1";

  // behavioural model state
  int m_reg[8];
  bit m_lock, m_key, m_viol;

  always #5 clk = ~clk;

  clk_cfg_lock u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lock_o(lock_o), .wait_req(wait_req),
    .wait_grant(wait_grant), .wait_violation(wait_violation),
    .ctl0_o(ctl0_o), .ctl1_o(ctl1_o), .ctl2_o(ctl2_o), .pll_o(pll_o)
  );

  task automatic model_reset();
    m_reg[0] = 'h48; m_reg[1] = 'h20; m_reg[2] = 'h00; m_reg[3] = 'h12;
    m_lock = 0; m_key = 0; m_viol = 0;
  endtask

  function automatic int model_read(int a);
    if (a < 4)  return m_reg[a];
    if (a == 4) return int'(m_lock);
    if (a == 5) return int'(m_key);
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  initial model_reset();

  // model update on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else begin
      int a;
      bit nl;
      int mask;
      a = int'(addr);
      nl = m_lock;
      m_viol = wait_req && m_lock;
      if (wr_en) begin
        if (a < 4) begin
          mask = 0;
          if (m_lock) mask = (a == 0) ? 'hA4 : (a == 1) ? 'h03 : (a == 2) ? 'h01 : 'hFF;
          m_reg[a] = (m_reg[a] & mask) | (int'(wdata) & ~mask & 'hFF);
        end else if (a == 5) m_key = wdata[0];
        else if (a == 4) begin
          if (m_key && wdata[0] && ((m_reg[0] & 'hA0) == 0)) nl = 1;
        end
      end
      m_lock = nl;
    end
  end

  // compare against model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(rdata == 8'(model_read(int'(addr))), phase, int'(rdata), model_read(int'(addr)));
      check(lock_o == m_lock, phase, int'(lock_o), int'(m_lock));
      check(wait_grant == (wait_req && !m_lock), phase, int'(wait_grant), int'(wait_req && !m_lock));
      check(wait_violation == m_viol, phase, int'(wait_violation), int'(m_viol));
    end
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      wr_en = 0; wait_req = 0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  // direct read with a hand-computed expectation
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk); #2;
    check(rdata == exp, tag, int'(rdata), int'(exp));
  endtask

  initial begin
    idle(3);
    @(negedge clk); #1; rst_n = 1;
    idle(4);

    phase = "R1";
    rd(0, 8'h48, "R1"); rd(1, 8'h20, "R1"); rd(2, 8'h00, "R1");
    rd(3, 8'h12, "R1"); rd(4, 8'h00, "R1"); rd(5, 8'h00, "R1");

    phase = "R11";
    rd(6, 8'h00, "R11"); rd(7, 8'h00, "R11");
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd(0, 8'h48, "R11"); rd(3, 8'h12, "R11");

    phase = "R9";
    @(negedge clk); #1; wait_req = 1;
    @(negedge clk); #2;
    check(wait_grant == 1'b1, "R9", int'(wait_grant), 1);
    #1 wait_req = 0;
    @(negedge clk); #2;
    check(wait_violation == 1'b0, "R10", int'(wait_violation), 0);

    phase = "R2";
    wr(4, 8'h01);
    rd(4, 8'h00, "R2");
    wr(5, 8'hFF);
    rd(5, 8'h01, "R2");

    phase = "R4";
    wr(0, 8'h68);  // stop bit set
    wr(4, 8'h01);
    rd(4, 8'h00, "R4");
    wr(0, 8'hC8);  // select bit set
    wr(4, 8'h01);
    rd(4, 8'h00, "R4");
    wr(0, 8'h48);

    phase = "R3";
    wr(4, 8'h01);
    rd(4, 8'h01, "R3");
    check(lock_o == 1'b1, "R3", int'(lock_o), 1);
    wr(5, 8'h00);

    phase = "R5";
    wr(5, 8'h01);
    wr(4, 8'h00);
    rd(4, 8'h01, "R5");
    wr(5, 8'h00);

    phase = "R6";
    wr(0, 8'hFF); rd(0, 8'h5B, "R6");
    wr(0, 8'h00); rd(0, 8'h00, "R8");
    wr(1, 8'hFF); rd(1, 8'hFC, "R6");
    wr(2, 8'hFF); rd(2, 8'hFE, "R8");

    phase = "R7";
    wr(3, 8'hA5); rd(3, 8'h12, "R7");
    wr(3, 8'h00); rd(3, 8'h12, "R7");

    phase = "R10";
    @(negedge clk); #1; wait_req = 1;
    @(negedge clk); #2;
    check(wait_grant == 1'b0, "R9", int'(wait_grant), 0);
    check(wait_violation == 1'b1, "R10", int'(wait_violation), 1);
    #1 wait_req = 0;
    @(negedge clk); #2;
    check(wait_violation == 1'b0, "R10", int'(wait_violation), 0);

    phase = "R5";
    @(negedge clk); #1; rst_n = 0;
    idle(2);
    @(negedge clk); #1; rst_n = 1;
    idle(4);
    rd(4, 8'h00, "R5");
    rd(3, 8'h12, "R1");
    wr(3, 8'h34); rd(3, 8'h34, "R7");

    idle(2);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule